// File: doc/BRIEF.md
# Serial Memory-Access Slave

This block is a serial-bus slave for SPI mode 0 with 8-bit words. It turns each chip-select framed transaction into byte reads or byte writes on a synchronous memory bus. A transaction opens with a three-byte header that carries a 22-bit byte address and a direction flag. A write header is followed directly by payload bytes. A read header is followed by one dummy byte, and the slave then shifts stored bytes out on MISO. In both directions the address advances by one after every byte, so a multi-byte value travels least significant byte first over consecutive addresses.

The same port also accepts three-byte host commands: a code byte followed by two zero bytes. A recognised code produces a one-cycle strobe: wake, core reset, external clock select or internal clock select. The wake code is 0x00, so its frame looks exactly like the start of a read of address 0. It is recognised because chip select rises right after the third byte, with no dummy bit clocked. For the same reason, every command strobe is raised when the frame closes.

SCK, MOSI and CS are oversampled in the system clock domain through a two-flop synchronizer. The memory is outside the block and must return read data one cycle after a read request.

Top module: `spi_memport_slave`

## Requirements
- R1: While reset is held and right after it is released, miso, mem_we, mem_re and all four command strobes are 0.
- R2: A frame whose first byte has bits 7:6 = 10 is a write. Address bits 21:16 come from that byte's bits 5:0, bits 15:8 from the second byte and bits 7:0 from the third byte. Each following complete byte produces exactly one single-cycle mem_we at the current address, carrying that byte on mem_wdata.
- R3: A frame whose first byte has bits 7:6 = 00 is a read. The header is followed by one dummy byte, during which MISO is 0. After that, MISO carries the bytes stored at the start address and the addresses above it, most significant bit first. MISO changes after falling SCK edges and is valid at the rising edge.
- R4: After each data byte the address advances by one and wraps from 0x3FFFFF to 0x000000, for both reads and writes.
- R5: If chip select rises part-way through a byte, that partial byte is discarded and produces no write.
- R6: A first byte with bit 6 = 1 starts a command frame. If the next two bytes are zero and chip select rises right after them, code 0x68 pulses cmd_core_rst, 0x44 pulses cmd_clk_ext and 0x62 pulses cmd_clk_int. Each strobe lasts one clock cycle. Any other code with bit 6 = 1 produces no strobe.
- R7: The frame 0x00 0x00 0x00 followed at once by chip-select release pulses cmd_wake for one cycle. If any further SCK bit is clocked before the release, no strobe is produced.
- R8: A command frame with a nonzero second or third byte, or with more than three bytes, produces no strobe.
- R9: MOSI data sent during the dummy byte and the read data phase is ignored and never produces a write.
- R10: While chip select is high, MISO is 0 and SCK/MOSI activity is ignored. The next frame is parsed from its first byte.
- R11: mem_we and mem_re are never asserted together, and each is asserted for one cycle per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host (idle low) |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select that frames a transaction |
| miso | output | 1 | Serial data to the host, registered |
| mem_addr | output | ADDR_W | Byte address of the memory access |
| mem_wdata | output | 8 | Byte to be written |
| mem_we | output | 1 | Single-cycle write request |
| mem_re | output | 1 | Single-cycle read request |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_re |
| cmd_wake | output | 1 | Wake command strobe |
| cmd_core_rst | output | 1 | Core reset command strobe |
| cmd_clk_ext | output | 1 | External clock select strobe |
| cmd_clk_int | output | 1 | Internal clock select strobe |

## Verification
A header parser that is out of step places writes at the wrong address or with the wrong count. This shows on the memory bus within a few clock cycles of the first payload byte. A stale prefetch buffer or a wrong phase state shows on MISO one SCK byte later, as a dummy byte that is not zero or as a read byte that differs from what was written. Command decoding errors show as a strobe missing or appearing at the moment chip select rises. To expose address wrap and aliasing faults, the bench sweeps burst lengths and start addresses near both ends of the address space and reads every burst back.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned HDR_ADDR_W = 22;
  localparam int unsigned BYTE_W     = 8;

  localparam logic [BYTE_W-1:0] CODE_WAKE     = 8'h00;
  localparam logic [BYTE_W-1:0] CODE_CORE_RST = 8'h68;
  localparam logic [BYTE_W-1:0] CODE_CLK_EXT  = 8'h44;
  localparam logic [BYTE_W-1:0] CODE_CLK_INT  = 8'h62;

  typedef enum logic [2:0] {
    PH_HDR0,
    PH_HDR1,
    PH_HDR2,
    PH_DUMMY,
    PH_RDATA,
    PH_WDATA,
    PH_CMDTAIL,
    PH_DROP
  } phase_t;

  typedef struct packed {
    logic wake;
    logic core_rst;
    logic clk_ext;
    logic clk_int;
  } cmd_pulse_t;
endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_pin,
  input  logic mosi_pin,
  input  logic cs_n_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_q,
  output logic sel,
  output logic sel_end
);
  // bit 2: cs_n, bit 1: mosi, bit 0: sck
  logic [STAGES-1:0][2:0] pipe;
  logic [2:0]             synced;
  logic                   sck_q;
  logic                   sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{3'b100}};
    end else begin
      pipe[0] <= {cs_n_pin, mosi_pin, sck_pin};
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign synced = pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= synced[0];
      sel_q <= ~synced[2];
    end
  end

  assign sck_rise = synced[0] & ~sck_q;
  assign sck_fall = ~synced[0] & sck_q;
  assign mosi_q   = synced[1];
  assign sel      = ~synced[2];
  assign sel_end  = sel_q & synced[2];
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         mosi_q,
  input  logic         tx_load_en,
  input  logic [W-1:0] tx_byte,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         bit_zero,
  output logic         miso
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bit_cnt;
  logic [W-2:0]  rx_sr;
  logic [W-1:0]  tx_sr;

  assign byte_done = sel & sck_rise & (bit_cnt == LAST);
  assign rx_byte   = {rx_sr, mosi_q};
  assign bit_zero  = (bit_cnt == '0);
  assign miso      = tx_sr[W-1];

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
    end else begin
      if (sck_rise) begin
        rx_sr   <= {rx_sr[W-3:0], mosi_q};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sck_fall) begin
        if (bit_cnt == '0) begin
          tx_sr <= tx_load_en ? tx_byte : '0;
        end else begin
          tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sel_end,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              bit_zero,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              tx_load_en,
  output logic [BYTE_W-1:0] tx_byte,
  output cmd_pulse_t        pulses
);
  localparam int AW = HDR_ADDR_W;
  localparam int HI = AW - 2 * BYTE_W;

  phase_t            phase;
  logic [AW-1:0]     addr;
  logic [AW-1:0]     hdr_addr;
  logic [BYTE_W-1:0] code;
  logic              tail_zero;
  logic              is_write;
  logic              is_cmd;
  logic              re_q;
  logic [BYTE_W-1:0] rd_buf;

  assign hdr_addr   = {addr[AW-1:BYTE_W], rx_byte};
  assign tx_load_en = (phase == PH_RDATA);
  assign tx_byte    = rd_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HDR0;
      addr      <= '0;
      code      <= '0;
      tail_zero <= 1'b0;
      is_write  <= 1'b0;
      is_cmd    <= 1'b0;
      re_q      <= 1'b0;
      rd_buf    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      pulses    <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      pulses <= '0;
      re_q   <= mem_re;
      if (re_q) rd_buf <= mem_rdata;

      // strobes are decided when the frame closes on a byte boundary
      if (sel_end && bit_zero && tail_zero) begin
        if (phase == PH_CMDTAIL) begin
          unique case (code)
            CODE_CORE_RST: pulses.core_rst <= 1'b1;
            CODE_CLK_EXT:  pulses.clk_ext  <= 1'b1;
            CODE_CLK_INT:  pulses.clk_int  <= 1'b1;
            default: ;
          endcase
        end else if (phase == PH_DUMMY && code == CODE_WAKE) begin
          pulses.wake <= 1'b1;
        end
      end

      if (!sel) begin
        phase <= PH_HDR0;
      end else if (byte_done) begin
        unique case (phase)
          PH_HDR0: begin
            code           <= rx_byte;
            addr[AW-1:2*BYTE_W] <= rx_byte[HI-1:0];
            tail_zero      <= 1'b1;
            is_write       <= (rx_byte[7:6] == 2'b10);
            is_cmd         <= rx_byte[6];
            phase          <= PH_HDR1;
          end
          PH_HDR1: begin
            addr[2*BYTE_W-1:BYTE_W] <= rx_byte;
            tail_zero <= tail_zero & (rx_byte == '0);
            phase     <= PH_HDR2;
          end
          PH_HDR2: begin
            tail_zero <= tail_zero & (rx_byte == '0);
            if (is_cmd) begin
              addr  <= hdr_addr;
              phase <= PH_CMDTAIL;
            end else if (is_write) begin
              addr  <= hdr_addr;
              phase <= PH_WDATA;
            end else begin
              // first read byte is fetched while the dummy byte shifts in
              mem_re   <= 1'b1;
              mem_addr <= hdr_addr[ADDR_W-1:0];
              addr     <= hdr_addr + 1'b1;
              phase    <= PH_DUMMY;
            end
          end
          PH_DUMMY: phase <= PH_RDATA;
          PH_RDATA: begin
            mem_re   <= 1'b1;
            mem_addr <= addr[ADDR_W-1:0];
            addr     <= addr + 1'b1;
          end
          PH_WDATA: begin
            mem_we    <= 1'b1;
            mem_addr  <= addr[ADDR_W-1:0];
            mem_wdata <= rx_byte;
            addr      <= addr + 1'b1;
          end
          PH_CMDTAIL: phase <= PH_DROP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_memport_slave.sv
module spi_memport_slave
  import spim_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              cmd_wake,
  output logic              cmd_core_rst,
  output logic              cmd_clk_ext,
  output logic              cmd_clk_int
);
  logic              sck_rise, sck_fall, mosi_q, sel, sel_end;
  logic              byte_done, bit_zero, tx_load_en;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  cmd_pulse_t        pulses;

  spim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck_pin  (sck),
    .mosi_pin (mosi),
    .cs_n_pin (cs_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_q   (mosi_q),
    .sel      (sel),
    .sel_end  (sel_end)
  );

  spim_shift #(.W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .mosi_q     (mosi_q),
    .tx_load_en (tx_load_en),
    .tx_byte    (tx_byte),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .bit_zero   (bit_zero),
    .miso       (miso)
  );

  spim_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .sel_end    (sel_end),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .bit_zero   (bit_zero),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .tx_load_en (tx_load_en),
    .tx_byte    (tx_byte),
    .pulses     (pulses)
  );

  assign cmd_wake     = pulses.wake;
  assign cmd_core_rst = pulses.core_rst;
  assign cmd_clk_ext  = pulses.clk_ext;
  assign cmd_clk_int  = pulses.clk_int;
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              miso,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              cmd_wake,
  input logic              cmd_core_rst,
  input logic              cmd_clk_ext,
  input logic              cmd_clk_int
);
  logic [3:0]        idle_cnt;
  logic [ADDR_W-1:0] prev_addr;
  logic [ADDR_W-1:0] next_addr;
  logic              have_prev;
  logic [3:0]        strobes;

  assign strobes   = {cmd_wake, cmd_core_rst, cmd_clk_ext, cmd_clk_int};
  assign next_addr = prev_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt  <= '0;
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else begin
      if (!cs_n) idle_cnt <= '0;
      else if (idle_cnt != 4'hF) idle_cnt <= idle_cnt + 1'b1;
      if (mem_we) begin
        prev_addr <= mem_addr;
        have_prev <= 1'b1;
      end else if (idle_cnt >= 4'd6) begin
        have_prev <= 1'b0;
      end
    end
  end

  assert_bus_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  assert_re_single_R11: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);

  assert_we_single_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && have_prev) |-> (mem_addr == next_addr));

  assert_cmd_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

  assert_cmd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (|strobes) |=> (strobes == 4'b0000));

  assert_miso_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= 4'd4) |-> !miso);
endmodule

bind spi_memport_slave spim_checker #(.ADDR_W(ADDR_W)) u_spim_checker (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .miso         (miso),
  .mem_addr     (mem_addr),
  .mem_we       (mem_we),
  .mem_re       (mem_re),
  .cmd_wake     (cmd_wake),
  .cmd_core_rst (cmd_core_rst),
  .cmd_clk_ext  (cmd_clk_ext),
  .cmd_clk_int  (cmd_clk_int)
);

// File: tb/spi_memport_slave_test.sv
`timescale 1ns/1ps
module spi_memport_slave_test;
  localparam int H = 6;  // clk cycles per SCK phase

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic        cs_n = 1'b1;
  logic        miso;
  logic [21:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata;
  logic        cmd_wake, cmd_core_rst, cmd_clk_ext, cmd_clk_int;

  always #4 clk = ~clk;  // 125 MHz

  spi_memport_slave uut (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .cmd_wake(cmd_wake), .cmd_core_rst(cmd_core_rst),
    .cmd_clk_ext(cmd_clk_ext), .cmd_clk_int(cmd_clk_int)
  );

  function automatic logic [7:0] init_b(input logic [9:0] i);
    logic [15:0] t;
    t = 16'(i) * 16'd7 + 16'd3;
    return t[7:0];
  endfunction

  function automatic logic [7:0] hi_of(input logic [21:0] a);
    return a[21:14];
  endfunction

  // memory model: one-cycle read latency, scrambled with high address bits
  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_b(10'(i));
      mem_rdata <= 8'h00;
    end else begin
      if (mem_re) mem_rdata <= mem[mem_addr[9:0]] ^ hi_of(mem_addr);
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata ^ hi_of(mem_addr);
    end
  end

  // bus and strobe monitor
  int         wcnt = 0;
  int         n_wake = 0, n_crst = 0, n_cext = 0, n_cint = 0;
  logic [21:0] wlog_a [0:63];
  logic [7:0]  wlog_d [0:63];
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        wlog_a[wcnt % 64] = mem_addr;
        wlog_d[wcnt % 64] = mem_wdata;
        wcnt = wcnt + 1;
      end
      if (cmd_wake)     n_wake = n_wake + 1;
      if (cmd_core_rst) n_crst = n_crst + 1;
      if (cmd_clk_ext)  n_cext = n_cext + 1;
      if (cmd_clk_int)  n_cint = n_cint + 1;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] sh [0:1023];   // bench shadow of raw memory contents
  logic [7:0] fbuf [0:23];
  logic [7:0] frx  [0:23];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    waitc(H);
    r = miso;
    sck = 1'b1;
    waitc(H);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  // nb whole bytes from fbuf, then 'extra' leading bits of fbuf[nb]
  task automatic frame(input int nb, input int extra);
    logic [7:0] rx;
    logic       r;
    cs_n = 1'b0;
    waitc(H);
    for (int i = 0; i < nb; i++) begin
      spi_byte(fbuf[i], rx);
      frx[i] = rx;
    end
    for (int j = 0; j < extra; j++) spi_bit(fbuf[nb][7-j], r);
    waitc(H);
    cs_n = 1'b1;
    mosi = 1'b0;
    waitc(2 * H);
  endtask

  function automatic logic [7:0] exp_rd(input logic [21:0] a);
    return sh[a[9:0]] ^ hi_of(a);
  endfunction

  task automatic do_write(input logic [21:0] a, input int n, input logic [7:0] seed, input string req);
    int base;
    fbuf[0] = {2'b10, a[21:16]};
    fbuf[1] = a[15:8];
    fbuf[2] = a[7:0];
    for (int i = 0; i < n; i++) fbuf[3+i] = seed + 8'(i * 29);
    base = wcnt;
    frame(3 + n, 0);
    chk({req, " write count"}, 32'(wcnt - base), 32'(n));
    for (int i = 0; i < n; i++) begin
      logic [21:0] ea;
      ea = a + 22'(i);
      chk({req, " write addr"}, 32'(wlog_a[(base + i) % 64]), 32'(ea));
      chk({req, " write data"}, 32'(wlog_d[(base + i) % 64]), 32'(fbuf[3+i]));
      sh[ea[9:0]] = fbuf[3+i] ^ hi_of(ea);
    end
  endtask

  task automatic do_read(input logic [21:0] a, input int n, input string req);
    int base;
    fbuf[0] = {2'b00, a[21:16]};
    fbuf[1] = a[15:8];
    fbuf[2] = a[7:0];
    for (int i = 0; i <= n; i++) fbuf[3+i] = 8'hFF;  // R9: MOSI held high
    base = wcnt;
    frame(4 + n, 0);
    chk({req, " dummy byte on MISO"}, 32'(frx[3]), 32'h0);
    for (int i = 0; i < n; i++)
      chk({req, " read data"}, 32'(frx[4+i]), 32'(exp_rd(a + 22'(i))));
    chk("R9 no write during read", 32'(wcnt - base), 32'h0);
  endtask

  task automatic do_cmd(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input int nb, input int extra, input logic [3:0] exp, input string req);
    int w0, c0, e0, i0;
    w0 = n_wake; c0 = n_crst; e0 = n_cext; i0 = n_cint;
    fbuf[0] = b0; fbuf[1] = b1; fbuf[2] = b2; fbuf[3] = 8'h00; fbuf[4] = 8'h00;
    frame(nb, extra);
    chk({req, " wake strobes"},     32'(n_wake - w0), 32'(exp[3]));
    chk({req, " core-rst strobes"}, 32'(n_crst - c0), 32'(exp[2]));
    chk({req, " clk-ext strobes"},  32'(n_cext - e0), 32'(exp[1]));
    chk({req, " clk-int strobes"},  32'(n_cint - i0), 32'(exp[0]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) sh[i] = init_b(10'(i));
    waitc(5);
    // R1: reset state
    chk("R1 miso in reset", 32'(miso), 0);
    chk("R1 we/re in reset", 32'({mem_we, mem_re}), 0);
    rst = 1'b0;
    waitc(3);
    chk("R1 miso after reset", 32'(miso), 0);
    chk("R1 strobes after reset",
        32'({cmd_wake, cmd_core_rst, cmd_clk_ext, cmd_clk_int}), 0);
    chk("R1 we/re after reset", 32'({mem_we, mem_re}), 0);

    // R2 / R3 basic write then read back past the burst end
    do_write(22'h012345, 4, 8'h11, "R2");
    do_read(22'h012345, 6, "R3");
    do_read(22'h2ABCDE, 3, "R3 unwritten high address");

    // R4: wrap at the top of the address space
    do_write(22'h3FFFFE, 3, 8'hA7, "R4");
    do_read(22'h3FFFFD, 5, "R4 read across wrap");

    // R5: frame closed part-way through the third payload byte
    begin
      int base;
      fbuf[0] = 8'h80; fbuf[1] = 8'h02; fbuf[2] = 8'h40;
      fbuf[3] = 8'h5A; fbuf[4] = 8'hC3; fbuf[5] = 8'hFF;
      base = wcnt;
      frame(5, 5);
      chk("R5 partial byte not written", 32'(wcnt - base), 32'd2);
      sh[10'h240] = 8'h5A; sh[10'h241] = 8'hC3;
      do_read(22'h000240, 3, "R5 readback");
    end

    // R6 commands
    do_cmd(8'h68, 8'h00, 8'h00, 3, 0, 4'b0100, "R6 core reset");
    do_cmd(8'h44, 8'h00, 8'h00, 3, 0, 4'b0010, "R6 clk ext");
    do_cmd(8'h62, 8'h00, 8'h00, 3, 0, 4'b0001, "R6 clk int");
    do_cmd(8'hC5, 8'h00, 8'h00, 3, 0, 4'b0000, "R6 unknown code");
    // R7 wake
    do_cmd(8'h00, 8'h00, 8'h00, 3, 0, 4'b1000, "R7 wake");
    do_cmd(8'h00, 8'h00, 8'h00, 3, 1, 4'b0000, "R7 wake with extra bit");
    do_cmd(8'h00, 8'h00, 8'h01, 3, 0, 4'b0000, "R7 nonzero address");
    // R8 malformed commands
    do_cmd(8'h68, 8'h01, 8'h00, 3, 0, 4'b0000, "R8 nonzero tail");
    do_cmd(8'h44, 8'h00, 8'h00, 4, 0, 4'b0000, "R8 extra byte");
    do_cmd(8'h62, 8'h00, 8'h00, 2, 0, 4'b0000, "R8 short frame");

    // R10: activity with chip select high is ignored
    begin
      logic r;
      mosi = 1'b1;
      for (int i = 0; i < 11; i++) begin
        waitc(H); sck = 1'b1; waitc(H); sck = 1'b0;
      end
      r = miso;
      chk("R10 miso idle", 32'(r), 0);
      mosi = 1'b0;
      waitc(2 * H);
      do_write(22'h000200, 1, 8'h3C, "R10 fresh frame");
    end

    // sweep of burst lengths and start addresses, each read back
    for (int len = 1; len <= 6; len++) begin
      logic [21:0] a;
      a = (len % 2 == 0) ? 22'(22'h3FFFFC - 22'(len)) : 22'(22'h000080 + 22'(len * 40));
      do_write(a, len, 8'(len * 13), "R2 sweep");
      do_read(a, len + 1, "R4 sweep readback");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule